// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Word Codec

This block carries a stream of words across a link that uses two wires per bit: a value wire and a phase wire. An encoder takes words from a valid/ready input and places each one on the link as a new token. For every bit, exactly one of its two wires changes per token. The value wire always shows the bit itself. The phase wire flips only when the bit repeats its previous value.

Because exactly one wire moves per bit, the XOR of a bit's two wires alternates between 0 and 1 on successive tokens. A decoder keeps the parity it expects for the next token. Once every bit's XOR equals that parity, it presents the word on its output for one cycle with a valid flag and flips the expected parity. The decoder's valid pulse also serves as an acknowledge to the encoder. The encoder takes no further word until that acknowledge arrives.

Top module: `ledr_codec`

## Requirements
- R1: While reset is low, and in the first cycle after it, every value and phase wire is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The value wires equal the accepted word from the cycle after acceptance onward, until the next acceptance.
- R3: Per token, for every bit, exactly one of its two wires changes: the value wire when the bit differs from the previous word, otherwise the phase wire.
- R4: The XOR of value and phase wires is all ones after the first token and alternates between all ones and all zeros on each later token.
- R5: `out_valid` rises exactly once per token, one cycle after the link changes, and lasts exactly one cycle. At that point `out_data` equals the accepted word.
- R6: Words arrive at the output in the order they were accepted, each exactly once.
- R7: From acceptance until the acknowledge, `in_ready` is 0. Any `in_valid` or `in_data` applied during that time has no effect on the link wires.
- R8: `in_ready` returns to 1 in the cycle after `out_valid` pulses. The next word can then be accepted at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | WIDTH | Word to encode |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Encoder can take a word |
| link_val | output | WIDTH | Value wire of each bit |
| link_phs | output | WIDTH | Phase wire of each bit |
| out_data | output | WIDTH | Decoded word |
| out_valid | output | 1 | `out_data` holds a new word, one-cycle pulse |

## Verification
The link assertions assume that only the encoder drives the wires and that it changes them only at an acceptance. They also assume that the decoder sees every token before the next one, which the acknowledge guarantees. The bench holds `in_valid` high with conflicting data during busy periods, so it probes the guarded window without ever breaking the handshake. Stimulus mixes fixed-seed random words with directed repeats and full-width inversions. These patterns push the phase wires and the value wires to their extremes.

// File: rtl/ledr_pkg.sv
// Shared helpers for the level-encoded dual-rail codec.
// Assumes: callers pass equal-width vectors.
package ledr_pkg;
    parameter int unsigned DEF_WIDTH = 8;

    // Phase wire after a token: flips on bits whose value repeats.
    function automatic logic [DEF_WIDTH-1:0] next_phase(
        input logic [DEF_WIDTH-1:0] phs,
        input logic [DEF_WIDTH-1:0] old_val,
        input logic [DEF_WIDTH-1:0] new_val);
        return phs ^ ~(old_val ^ new_val);
    endfunction
endpackage

// File: rtl/ledr_encoder.sv
// Encoder: takes a word on valid/ready and drives it onto the link as one
// token, in which exactly one wire of each bit toggles.
// Assumes: ack pulses once per token, after the token was placed on the link.
module ledr_encoder #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             ack,
    output logic [WIDTH-1:0] link_val,
    output logic [WIDTH-1:0] link_phs
);
    logic [WIDTH-1:0] val_q;
    logic [WIDTH-1:0] phs_q;
    logic             busy_q;
    logic             take;

    // Acceptance happens only while no token is outstanding.
    always_comb begin
        in_ready = !busy_q;
        take     = in_valid && !busy_q;
    end

    // Link registers and the outstanding-token flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            phs_q  <= '0;
            busy_q <= 1'b0;
        end else if (take) begin
            val_q  <= in_data;
            phs_q  <= phs_q ^ ~(val_q ^ in_data);
            busy_q <= 1'b1;
        end else if (ack) begin
            busy_q <= 1'b0;
        end
    end

    assign link_val = val_q;
    assign link_phs = phs_q;

    AST_ONE_WIRE_PER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> (((link_val ^ $past(link_val)) ^ (link_phs ^ $past(link_phs))) == {WIDTH{1'b1}})) else $error("one wire per bit"); // R3
    AST_VALUE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> (link_val == $past(in_data))) else $error("value wire"); // R2
    AST_LINK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take) |-> ($stable(link_val) && $stable(link_phs))) else $error("link moved"); // R7
    AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> in_ready) else $error("ready after ack"); // R8
endmodule

// File: rtl/ledr_parity_detect.sv
// Completion detector: per bit, compares value XOR phase with the expected
// parity and combines all bits into one "token complete" flag.
// Assumes: pure combinational, no state.
module ledr_parity_detect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] link_val,
    input  logic [WIDTH-1:0] link_phs,
    input  logic             want_par,
    output logic             complete
);
    logic [WIDTH-1:0] bit_ok;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // One bit has reached the expected phase.
        assign bit_ok[b] = (link_val[b] ^ link_phs[b]) == want_par;
    end

    // All bits have arrived.
    assign complete = &bit_ok;
endmodule

// File: rtl/ledr_decoder.sv
// Decoder: watches the link, raises a one-cycle valid with the word once every
// bit reaches the expected parity, then flips the parity it waits for.
// Assumes: the link does not change again before the valid pulse.
module ledr_decoder #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] link_val,
    input  logic [WIDTH-1:0] link_phs,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);
    logic want_q;
    logic done;

    ledr_parity_detect #(.WIDTH(WIDTH)) u_det (
        .link_val (link_val),
        .link_phs (link_phs),
        .want_par (want_q),
        .complete (done)
    );

    // Capture the word and flip the expected parity when a token completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q    <= 1'b1;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_data <= link_val;
                want_q   <= !want_q;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid) else $error("valid pulse"); // R5
    AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (want_q != $past(want_q))) else $error("parity flip"); // R4
    AST_WORD_ON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(link_val))) else $error("word"); // R6
endmodule

// File: rtl/ledr_codec.sv
// Top: encoder and decoder joined by the dual-rail link; the decoder's valid
// pulse is the acknowledge that releases the encoder.
// Assumes: both halves share one clock and reset.
module ledr_codec #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [WIDTH-1:0] link_val,
    output logic [WIDTH-1:0] link_phs,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);
    ledr_encoder #(.WIDTH(WIDTH)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .ack      (out_valid),
        .link_val (link_val),
        .link_phs (link_phs)
    );

    ledr_decoder #(.WIDTH(WIDTH)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_val  (link_val),
        .link_phs  (link_phs),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_valid) |=> !in_ready) else $error("ready early"); // R7
endmodule

// File: tb/tb_ledr_codec.sv
module tb_ledr_codec;
    localparam int W = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready, out_valid;
    logic [W-1:0] link_val, link_phs, out_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m_val = '0;
    logic [W-1:0] m_phs = '0;
    logic m_par = 1'b1;
    bit finished = 0;

    always #2 clk = ~clk;

    ledr_codec #(.WIDTH(W)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_phase(input logic [W-1:0] p, input logic [W-1:0] o, input logic [W-1:0] n);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++) r[b] = (o[b] == n[b]) ? ~p[b] : p[b];
        return r;
    endfunction

    task automatic send(input logic [W-1:0] w);
        logic [W-1:0] ep;
        @(negedge clk);
        in_data = w; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        // accepted; now offer conflicting data while busy (R7)
        in_data = ~w;
        ep = exp_phase(m_phs, m_val, w);
        chk(link_val == w, "R2", link_val, w);
        chk(link_phs == ep, "R3", link_phs, ep);
        chk(((link_val ^ m_val) ^ (link_phs ^ m_phs)) == '1, "R3", (link_val ^ m_val) ^ (link_phs ^ m_phs), '1);
        chk((link_val ^ link_phs) == {W{m_par}}, "R4", link_val ^ link_phs, {W{m_par}});
        chk(!in_ready, "R7", W'(in_ready), '0);
        chk(!out_valid, "R5", W'(out_valid), '0);
        @(negedge clk);
        chk(out_valid && out_data == w, "R5 R6", out_data, w);
        chk(link_val == w && link_phs == ep, "R7", link_val, w);
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R5", W'(out_valid), '0);
        chk(in_ready, "R8", W'(in_ready), 1);
        chk(link_val == w && link_phs == ep, "R7", link_phs, ep);
        m_val = w; m_phs = ep; m_par = ~m_par;
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(link_val == '0 && link_phs == '0, "R1", link_val | link_phs, '0);
        chk(!out_valid && in_ready, "R1", {out_valid, in_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(link_val == '0 && link_phs == '0 && !out_valid && in_ready, "R1", link_phs, '0);
        send('0);
        send('0);
        send('1);
        send('1);
        send(8'hA5);
        send(8'h5A);
        send(8'h5A);
        for (int i = 0; i < 60; i++) send(W'($urandom));
        // idle: nothing should appear at the output
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid, "R6", W'(out_valid), '0);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule